// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block is the column-burst engine inside a synchronous DRAM device model. Each clock it samples one already-decoded command. The command can start a read burst or a write burst, or it can end the burst that is running. The block steps a column counter that wraps inside the burst boundary. Write data is stored in a small internal page array. Read data passes through a latency pipeline, so each word reaches the data bus a programmable number of cycles after it was fetched.

A read burst can be cut short by a stop command or by a precharge. Words fetched before the cut still drain out of the pipeline, and the bus floats exactly one latency after the cut. A write burst cut the same way discards the data of the cutting cycle. Every later cycle is also discarded until a fresh write command arrives. A new read or write command given during a burst replaces that burst at once.

Top module: `sdram_burst_engine`

## Requirements
- R1: While reset is held, and after it is released with no command, `dqOe` is 0 and `dqHiZ` is 1.
- R2: Command codes on `cmd` are: 0 no-op, 1 READ, 2 WRITE, 3 burst stop, 4 precharge; codes 5 to 7 act as no-op. A READ sampled in cycle t fetches one word per cycle from cycle t onward. The word fetched in cycle i is on `dqOut`, with `dqOe` high, in cycle i+L, where L is `casLat` (1, 2 or 3; code 0 acts as 1).
- R3: `burstSel` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words; any other code gives a full page of 2^COL_W words. A burst with no stop or new command ends by itself after that many words.
- R4: Word i of a burst of length B that starts at column s uses column (s with its low log2(B) bits cleared) OR ((s+i) mod B).
- R5: If a burst stop arrives in cycle s during a read burst, the words fetched before cycle s are still output. No word is fetched from cycle s onward, and the bus is released (`dqOe`=0) from cycle s+L.
- R6: A precharge during a read burst ends it with the same timing as R5.
- R7: A WRITE in cycle t stores `dqIn` of cycle t at the given column. Each following no-op cycle of the burst stores that cycle's `dqIn` at the next column in R4 order. Write timing does not depend on `casLat`.
- R8: A burst stop during a write burst stores nothing in its own cycle or any later cycle until a new WRITE is given.
- R9: A precharge during a write burst has the same effect as R8.
- R10: A READ given while a burst is active ends that burst in the same cycle and starts a new one at the new column. The output keeps exactly the earlier burst's words fetched before that cycle.
- R11: Outside the read output window, `dqOe` is 0 and `dqHiZ` is 1. This includes every cycle of a write burst that starts after earlier reads have drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmd | input | 3 | Decoded command code (see R2) |
| colAddr | input | COL_W | Start column for READ or WRITE |
| burstSel | input | 3 | Burst length code (see R3) |
| casLat | input | 2 | Read latency in cycles |
| dqIn | input | DATA_W | Write data from the bus |
| dqOut | output | DATA_W | Read data to the bus |
| dqOe | output | 1 | Bus output enable |
| dqHiZ | output | 1 | High when the bus floats |

## Verification
Two events can meet in one cycle. The first is a termination or a restarting READ landing in a cycle where the latency pipeline still holds words of the running burst. The second is a write command landing in the same cycle as a stop. Stop and precharge are each swept over every offset from the first to past the last word of a read burst, for each latency. Every cycle's expected bus state is computed from a fetch schedule built in the bench. After each terminated write, a full-page read compares the whole array with a reference image kept by the bench.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  localparam logic [2:0] CMD_NOP   = 3'd0;
  localparam logic [2:0] CMD_READ  = 3'd1;
  localparam logic [2:0] CMD_WRITE = 3'd2;
  localparam logic [2:0] CMD_BSTOP = 3'd3;
  localparam logic [2:0] CMD_PRECH = 3'd4;

  typedef struct packed {
    logic rdIssue;  // fetch a word into the latency pipe this cycle
    logic wrEn;     // store dqIn into the array this cycle
  } sbe_strobe_t;

endpackage

// File: rtl/sbe_ctrl.sv
module sbe_ctrl
  import sbe_pkg::*;
#(
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic [COL_W-1:0] colAddr,
  input  logic [2:0]       burstSel,
  output sbe_strobe_t      strb,
  output logic [COL_W-1:0] col
);

  localparam int LEN_W = COL_W + 1;
  localparam int PAGE  = 1 << COL_W;

  logic             active;
  logic             isWr;
  logic [COL_W-1:0] startCol;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] lenReg;

  logic [LEN_W-1:0] lenNow;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] burstCol;
  logic             cmdRd, cmdWr, cmdNew, cmdTerm, cont;
  logic [LEN_W-1:0] idxNext;

  function automatic logic [LEN_W-1:0] lenOf(input logic [2:0] sel);
    case (sel)
      3'd0:    lenOf = LEN_W'(1);
      3'd1:    lenOf = LEN_W'(2);
      3'd2:    lenOf = LEN_W'(4);
      3'd3:    lenOf = LEN_W'(8);
      default: lenOf = LEN_W'(PAGE);
    endcase
  endfunction

  always_comb begin
    cmdRd    = (cmd == CMD_READ);
    cmdWr    = (cmd == CMD_WRITE);
    cmdNew   = cmdRd || cmdWr;
    cmdTerm  = (cmd == CMD_BSTOP) || (cmd == CMD_PRECH);
    cont     = active && !cmdNew && !cmdTerm;
    lenNow   = lenOf(burstSel);
    mask     = COL_W'(lenReg - LEN_W'(1));
    burstCol = (startCol & ~mask) | ((startCol + idx[COL_W-1:0]) & mask);
    col      = cmdNew ? colAddr : burstCol;
    idxNext  = idx + LEN_W'(1);
    strb.rdIssue = cmdRd || (cont && !isWr);
    strb.wrEn    = cmdWr || (cont && isWr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      isWr     <= 1'b0;
      startCol <= '0;
      idx      <= '0;
      lenReg   <= LEN_W'(1);
    end else if (cmdNew) begin
      active   <= (lenNow > LEN_W'(1));
      isWr     <= cmdWr;
      startCol <= colAddr;
      idx      <= LEN_W'(1);
      lenReg   <= lenNow;
    end else if (cont) begin
      idx      <= idxNext;
      active   <= (idxNext < lenReg);
    end else if (cmdTerm) begin
      active   <= 1'b0;
    end
  end

  // R8: after a termination, nothing is fetched or stored until a new command
  p_halt_after_term_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd == CMD_BSTOP) || (cmd == CMD_PRECH)) |=>
      ((cmd == CMD_READ) || (cmd == CMD_WRITE) || !(strb.rdIssue || strb.wrEn)));

  // R3: the running word index never reaches the burst length
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (idx < lenReg));

  // R4: continuing columns stay inside the aligned burst window
  p_wrap_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    cont |-> (((col ^ startCol) & ~mask) == '0));

  // R7: a WRITE stores in its own cycle at the given column
  p_write_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_WRITE) |-> (strb.wrEn && !strb.rdIssue && (col == colAddr)));

endmodule

// File: rtl/sbe_dpath.sv
module sbe_dpath
  import sbe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 5,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbe_strobe_t       strb,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] dqIn,
  input  logic [1:0]        casLat,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);

  localparam int PAGE = 1 << COL_W;

  logic [DATA_W-1:0] mem [PAGE];
  logic [DATA_W-1:0] rdWord;

  logic [MAX_CL:1]   pv;
  logic [MAX_CL:1]   nxtV;
  logic [DATA_W-1:0] pd   [1:MAX_CL];
  logic [DATA_W-1:0] nxtD [1:MAX_CL];
  int                sel;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[col] <= dqIn;
  end

  assign rdWord = mem[col];

  for (genvar k = 1; k <= MAX_CL; k++) begin : g_stage
    if (k == 1) begin : g_head
      assign nxtV[k] = strb.rdIssue;
      assign nxtD[k] = rdWord;
    end else begin : g_tail
      assign nxtV[k] = pv[k-1];
      assign nxtD[k] = pd[k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pv <= '0;
      for (int k = 1; k <= MAX_CL; k++) pd[k] <= '0;
    end else begin
      pv <= nxtV;
      for (int k = 1; k <= MAX_CL; k++) pd[k] <= nxtD[k];
    end
  end

  always_comb begin
    if (casLat == 2'd0)              sel = 1;
    else if (int'(casLat) > MAX_CL)  sel = MAX_CL;
    else                             sel = int'(casLat);
    dqOe  = 1'b0;
    dqOut = '0;
    for (int k = 1; k <= MAX_CL; k++) begin
      if (k == sel) begin
        dqOe  = pv[k];
        dqOut = pv[k] ? pd[k] : '0;
      end
    end
  end

  // R2: at latency one a fetch shows on the bus in the next cycle
  p_issue_lat1_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((casLat == 2'd1) && strb.rdIssue) |=> ((casLat != 2'd1) || dqOe));

  // R5: at latency one the bus floats the cycle after fetching stops
  p_float_lat1_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((casLat == 2'd1) && !strb.rdIssue) |=> ((casLat != 2'd1) || !dqOe));

endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sbe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 5,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic [COL_W-1:0]  colAddr,
  input  logic [2:0]        burstSel,
  input  logic [1:0]        casLat,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic              dqHiZ
);

  sbe_strobe_t      strb;
  logic [COL_W-1:0] col;

  sbe_ctrl #(.COL_W(COL_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .colAddr  (colAddr),
    .burstSel (burstSel),
    .strb     (strb),
    .col      (col)
  );

  sbe_dpath #(.DATA_W(DATA_W), .COL_W(COL_W), .MAX_CL(MAX_CL)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .col    (col),
    .dqIn   (dqIn),
    .casLat (casLat),
    .dqOut  (dqOut),
    .dqOe   (dqOe)
  );

  assign dqHiZ = !dqOe;

endmodule

// File: tb/sdram_burst_engine_tb_top.sv
`timescale 1ns/1ps
module sdram_burst_engine_tb_top;

  localparam int DW   = 16;
  localparam int CW   = 5;
  localparam int PAGE = 1 << CW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [2:0]    cmd;
  logic [CW-1:0] colAddr;
  logic [2:0]    burstSel;
  logic [1:0]    casLat;
  logic [DW-1:0] dqIn;
  logic [DW-1:0] dqOut;
  logic          dqOe;
  logic          dqHiZ;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;
  logic [DW-1:0] refMem [PAGE];

  always #2 clk = ~clk;

  sdram_burst_engine #(.DATA_W(DW), .COL_W(CW), .MAX_CL(3)) dut_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .colAddr(colAddr), .burstSel(burstSel),
    .casLat(casLat), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe), .dqHiZ(dqHiZ)
  );

  function automatic int lenOf(int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return PAGE;
    endcase
  endfunction

  function automatic int wrapCol(int st, int i, int len);
    int m = len - 1;
    return (st & ~m & (PAGE - 1)) | ((st + i) & m);
  endfunction

  function automatic logic [DW-1:0] pat(int seed, int i);
    return DW'((seed * 37 + i * 131 + 5) ^ (i << 9) ^ (seed << 12));
  endfunction

  task automatic check(string tag, logic expOe, logic [DW-1:0] expD);
    vecs++;
    if (dqOe !== expOe || dqHiZ !== !expOe || (expOe && dqOut !== expD)) begin
      errs++;
      $display("FAIL %s: oe=%0b hiz=%0b data=%h, expected oe=%0b hiz=%0b data=%h",
               tag, dqOe, dqHiZ, dqOut, expOe, !expOe, expD);
    end
  endtask

  // Read burst with optional event (stop, precharge or restarting READ) at cycle evAt
  task automatic runRead(int cl, int bs, int col, int evAt, int evCmd, int col2, string tag);
    int len = lenOf(bs);
    logic sv [64];
    logic [DW-1:0] sd [64];
    for (int i = 0; i < 64; i++) begin
      sv[i] = 1'b0;
      sd[i] = '0;
    end
    for (int i = 0; i < len; i++) begin
      if (evAt < 0 || i < evAt) begin
        sv[i] = 1'b1;
        sd[i] = refMem[wrapCol(col, i, len)];
      end
    end
    if (evCmd == 1 && evAt >= 0) begin
      for (int j = 0; j < len; j++) begin
        if (evAt + j < 64) begin
          sv[evAt + j] = 1'b1;
          sd[evAt + j] = refMem[wrapCol(col2, j, len)];
        end
      end
    end
    casLat = 2'(cl);
    for (int c = 0; c < 60; c++) begin
      int i;
      @(negedge clk);
      i = c - cl;
      check(tag, (i >= 0) ? sv[i] : 1'b0, (i >= 0) ? sd[i] : '0);
      if (c == 0) begin
        cmd = 3'd1; colAddr = CW'(col); burstSel = 3'(bs);
      end else if (c == evAt) begin
        cmd = 3'(evCmd); colAddr = CW'(col2);
      end else begin
        cmd = 3'd0;
      end
    end
  endtask

  // Write burst with optional stop/precharge at cycle stopAt; bus must stay released (R11)
  task automatic runWrite(int bs, int col, int stopAt, int stopCmd, int seed, string tag);
    int len = lenOf(bs);
    for (int c = 0; c <= len + 3; c++) begin
      @(negedge clk);
      check({tag, " R11"}, 1'b0, '0);
      if (c == 0) begin
        cmd = 3'd2; colAddr = CW'(col); burstSel = 3'(bs);
      end else if (c == stopAt) begin
        cmd = 3'(stopCmd);
      end else begin
        cmd = 3'd0;
      end
      dqIn = pat(seed, c);
    end
    for (int i = 0; i < len; i++)
      if (stopAt < 0 || i < stopAt) refMem[wrapCol(col, i, len)] = pat(seed, i);
  endtask

  initial begin
    int seed = 1;
    rstN = 1'b0; cmd = 3'd0; colAddr = '0; burstSel = 3'd0; casLat = 2'd1; dqIn = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, '0);

    // fill the page (R7, full page length R3)
    runWrite(7, 0, -1, 0, seed, "R7 R3 fill");
    seed++;

    // read sweep: latency x length x start column (R2 R3 R4)
    for (int cl = 1; cl <= 3; cl++)
      foreach (lenCodes[k])
        for (int s = 0; s < 4; s++)
          runRead(cl, lenCodes[k], startCols[s], -1, 0, 0, "R2 R3 R4 read");

    // read termination at every offset (R5 stop, R6 precharge)
    for (int cl = 1; cl <= 3; cl++)
      for (int s = 1; s <= 9; s++) begin
        runRead(cl, 3, 6, s, 3, 0, "R5 stop");
        runRead(cl, 3, 6, s, 4, 0, "R6 precharge");
      end

    // restart by new READ (R10)
    for (int cl = 1; cl <= 3; cl++) begin
      runRead(cl, 2, 9, 2, 1, 21, "R10 restart");
      runRead(cl, 3, 3, 5, 1, 28, "R10 restart");
    end

    // write termination sweep (R7 R8 R9), each followed by full-page compare
    foreach (lenCodes[k])
      foreach (stopOffs[j]) begin
        int sc = (seed % 2 == 0) ? 3 : 4;
        string t = (stopOffs[j] < 0) ? "R7" : ((sc == 3) ? "R8" : "R9");
        runWrite(lenCodes[k], 4 + 3 * j, stopOffs[j], sc, seed, t);
        runRead(2, 7, 0, -1, 0, 0, {t, " array"});
        seed++;
      end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    finished = 1'b1;
    $finish;
  end

  int lenCodes [5] = '{0, 1, 2, 3, 7};
  int startCols [4] = '{0, 5, 13, 30};
  int stopOffs [5] = '{-1, 1, 2, 3, 5};

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule